// File: doc/BRIEF.md
# Bit-Column Deduplication and Pairing Unit

This block takes one tile of bit-columns cut from bit-expanded neural network weights and works out how to store it with as few physical columns as possible. The tile holds `NUM_COLS` columns of `COL_ROWS` bits each, and all of them belong to one crossbar operation unit. The block discards columns that carry no set bit. It keeps a single stored copy of each distinct nonzero column, and builds a remap code that points every original column at its stored slot.

The block also measures how alike the columns are. It counts the differing bits (the Hamming distance) for every column pair, one pair per clock. A greedy pass then marks the closest pairs of stored columns as candidates for merging. Nearest pairs are taken first, and ties go to the lower column indices.

After a `start` pulse the unit runs for a fixed number of cycles. It then raises `done_o` for one cycle and presents the compacted column list, the remap codes and the chosen pairs. These outputs hold until the next tile completes.

Top module: `bitcol_compactor`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `slot_cnt_o` and `pair_cnt_o` are 0, `slot_cols_o` and all pair fields are 0, and every remap code is all ones.
- R2: `start_i` is sampled only when `busy_o` is 0. A `start_i` pulse while busy is ignored, and the results are those of the tile already accepted.
- R3: If `start_i` is sampled at clock edge n, `busy_o` is 1 from edge n to edge n+33. `done_o` is 1 for exactly one cycle, from edge n+33 to edge n+34 (with defaults: 28 distance cycles plus 4 pairing cycles plus 2). At that point `busy_o` is already 0.
- R4: Column k of `tile_i` is bits [k*COL_ROWS +: COL_ROWS]. A column whose bits are all 0 gets remap code all ones (15 with defaults) and no stored slot.
- R5: A nonzero column that equals an earlier column (Hamming distance 0) gets the remap code of the earliest equal column, and takes no new slot.
- R6: Each nonzero column that is not a repeat gets a new slot, in increasing column order starting at slot 0. Its remap code (field k at [k*4 +: 4]) is that slot number. Slot s of `slot_cols_o` at [s*COL_ROWS +: COL_ROWS] holds that column. `slot_cnt_o` is the number of slots used, and unused slots read 0.
- R7: For each chosen pair, `pair_dist_o` (entry p at [p*5 +: 5]) equals the number of rows in which the two columns differ.
- R8: Pairs are chosen greedily among stored, still-unpaired columns. The pair with the smallest distance is taken first. Ties go to the smaller first index, then the smaller second index. In each entry, `pair_a_o` (entry p at [p*3 +: 3]) holds the lower column index and `pair_b_o` the higher.
- R9: Entries appear in order of selection, and `pair_cnt_o` equals floor(slot_cnt_o/2). Entries past the count read 0. Zero columns and repeated columns are never paired.
- R10: All result outputs change only on the edge that raises `done_o`, and they hold their values after `done_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept the tile on `tile_i` when idle |
| tile_i | input | NUM_COLS*COL_ROWS | Tile of bit-columns, column k at [k*COL_ROWS +: COL_ROWS] |
| busy_o | output | 1 | A tile is being processed |
| done_o | output | 1 | One-cycle pulse when the results are updated |
| slot_cnt_o | output | $clog2(NUM_COLS+1) | Number of stored columns |
| slot_cols_o | output | NUM_COLS*COL_ROWS | Compacted column list, slot-ordered |
| remap_o | output | NUM_COLS*($clog2(NUM_COLS)+1) | Per-column slot number, all ones for a dropped column |
| pair_cnt_o | output | $clog2(NUM_COLS/2+1) | Number of chosen pairs |
| pair_a_o | output | (NUM_COLS/2)*$clog2(NUM_COLS) | Lower column index of each pair |
| pair_b_o | output | (NUM_COLS/2)*$clog2(NUM_COLS) | Higher column index of each pair |
| pair_dist_o | output | (NUM_COLS/2)*$clog2(COL_ROWS+1) | Hamming distance of each pair |

## Verification
A wrong entry in the distance table can only be seen at `done_o`, because nothing is visible while the unit is busy. It then shows up as a repeated column that was stored twice, as a wrong pair choice, or as a wrong reported distance. A fault in the sequencing counters moves the `done_o` pulse away from its fixed cycle. Comparing `busy_o` and `done_o` against a behavioural model on every clock exposes such a fault in the cycle where it happens. The results are compared in full in the `done_o` cycle and again one cycle later. Tiles are built to hit distance ties, chains of repeats, all-zero and all-equal tiles, and a start request made while busy.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIST = 2'd1,
      ST_PICK = 2'd2,
      ST_DONE = 2'd3
   } bcc_state_e;
endpackage

// File: rtl/bcc_dist_engine.sv
module bcc_dist_engine #(
   parameter int NUM_COLS = 8,
   parameter int COL_ROWS = 16,
   parameter int IDX_W    = $clog2(NUM_COLS),
   parameter int DIST_W   = $clog2(COL_ROWS + 1)
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       run,
   input  logic [NUM_COLS*COL_ROWS-1:0]               tile,
   output logic [NUM_COLS-1:0][NUM_COLS-1:0][DIST_W-1:0] dist_tab,
   output logic                                       last
);
   logic [IDX_W-1:0]  i_q, j_q;
   logic [COL_ROWS-1:0] diff;
   logic [DIST_W-1:0] pop;

   always_comb begin
      diff = tile[i_q*COL_ROWS +: COL_ROWS] ^ tile[j_q*COL_ROWS +: COL_ROWS];
      pop  = '0;
      for (int r = 0; r < COL_ROWS; r++) pop = pop + DIST_W'(diff[r]);
   end

   assign last = run && (i_q == IDX_W'(NUM_COLS - 2)) && (j_q == IDX_W'(NUM_COLS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_q      <= '0;
         j_q      <= IDX_W'(1);
         dist_tab <= '0;
      end else if (!run) begin
         i_q <= '0;
         j_q <= IDX_W'(1);
      end else begin
         dist_tab[i_q][j_q] <= pop;
         if (j_q == IDX_W'(NUM_COLS - 1)) begin
            i_q <= i_q + IDX_W'(1);
            j_q <= i_q + IDX_W'(2);
         end else begin
            j_q <= j_q + IDX_W'(1);
         end
      end
   end

   // R7: a pair never differs in more rows than a column has
   assert_dist_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pop <= DIST_W'(COL_ROWS)));
   // R3: the sweep only visits pairs with the first index below the second
   assert_sweep_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (i_q < j_q));
endmodule

// File: rtl/bcc_remap.sv
module bcc_remap #(
   parameter int NUM_COLS = 8,
   parameter int COL_ROWS = 16,
   parameter int IDX_W    = $clog2(NUM_COLS),
   parameter int CODE_W   = IDX_W + 1,
   parameter int DIST_W   = $clog2(COL_ROWS + 1),
   parameter int CNT_W    = $clog2(NUM_COLS + 1)
) (
   input  logic [NUM_COLS*COL_ROWS-1:0]                  tile,
   input  logic [NUM_COLS-1:0][NUM_COLS-1:0][DIST_W-1:0] dist_tab,
   output logic [NUM_COLS-1:0]                           rep,
   output logic [NUM_COLS-1:0][CODE_W-1:0]               code,
   output logic [NUM_COLS-1:0][COL_ROWS-1:0]             slots,
   output logic [CNT_W-1:0]                              cnt
);
   localparam logic [CODE_W-1:0] DROP_CODE = '1;

   logic [NUM_COLS-1:0] nz;

   always_comb begin
      logic              hit;
      logic [CODE_W-1:0] hit_code;
      nz    = '0;
      rep   = '0;
      code  = '0;
      slots = '0;
      cnt   = '0;
      for (int j = 0; j < NUM_COLS; j++) begin
         nz[j]    = |tile[j*COL_ROWS +: COL_ROWS];
         hit      = 1'b0;
         hit_code = '0;
         for (int i = 0; i < j; i++) begin
            if (!hit && nz[i] && (dist_tab[i][j] == '0)) begin
               hit      = 1'b1;
               hit_code = code[i];
            end
         end
         if (!nz[j]) begin
            code[j] = DROP_CODE;
         end else if (hit) begin
            code[j] = hit_code;
         end else begin
            rep[j]                = 1'b1;
            code[j]               = CODE_W'(cnt);
            slots[cnt[IDX_W-1:0]] = tile[j*COL_ROWS +: COL_ROWS];
            cnt                   = cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/bcc_pair_picker.sv
module bcc_pair_picker #(
   parameter int NUM_COLS = 8,
   parameter int COL_ROWS = 16,
   parameter int IDX_W    = $clog2(NUM_COLS),
   parameter int DIST_W   = $clog2(COL_ROWS + 1)
) (
   input  logic [NUM_COLS-1:0][NUM_COLS-1:0][DIST_W-1:0] dist_tab,
   input  logic [NUM_COLS-1:0]                           eligible,
   output logic                                          found,
   output logic [IDX_W-1:0]                              best_a,
   output logic [IDX_W-1:0]                              best_b,
   output logic [DIST_W-1:0]                             best_d
);
   always_comb begin
      found  = 1'b0;
      best_a = '0;
      best_b = '0;
      best_d = '0;
      for (int a = 0; a < NUM_COLS; a++) begin
         for (int b = a + 1; b < NUM_COLS; b++) begin
            if (eligible[a] && eligible[b] && (!found || (dist_tab[a][b] < best_d))) begin
               found  = 1'b1;
               best_a = IDX_W'(a);
               best_b = IDX_W'(b);
               best_d = dist_tab[a][b];
            end
         end
      end
   end
endmodule

// File: rtl/bitcol_compactor.sv
module bitcol_compactor #(
   parameter int NUM_COLS = 8,
   parameter int COL_ROWS = 16,
   localparam int IDX_W   = $clog2(NUM_COLS),
   localparam int CODE_W  = IDX_W + 1,
   localparam int DIST_W  = $clog2(COL_ROWS + 1),
   localparam int CNT_W   = $clog2(NUM_COLS + 1),
   localparam int NPAIR   = NUM_COLS / 2,
   localparam int PCNT_W  = $clog2(NPAIR + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [NUM_COLS*COL_ROWS-1:0] tile_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic [CNT_W-1:0]             slot_cnt_o,
   output logic [NUM_COLS*COL_ROWS-1:0] slot_cols_o,
   output logic [NUM_COLS*CODE_W-1:0]   remap_o,
   output logic [PCNT_W-1:0]            pair_cnt_o,
   output logic [NPAIR*IDX_W-1:0]       pair_a_o,
   output logic [NPAIR*IDX_W-1:0]       pair_b_o,
   output logic [NPAIR*DIST_W-1:0]      pair_dist_o
);
   import bcc_pkg::*;

   localparam int PIDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
   localparam logic [CODE_W-1:0] DROP_CODE = '1;

   if (NUM_COLS < 2) begin : g_bad_cols
      $error("bitcol_compactor: NUM_COLS must be at least 2");
   end
   if (COL_ROWS < 1) begin : g_bad_rows
      $error("bitcol_compactor: COL_ROWS must be at least 1");
   end

   bcc_state_e state_q;
   logic [NUM_COLS*COL_ROWS-1:0] tile_q;
   logic [PCNT_W-1:0] round_q;
   logic [NUM_COLS-1:0] used_q;

   logic [PCNT_W-1:0]                 wcnt_q;
   logic [NPAIR-1:0][IDX_W-1:0]       wa_q, wb_q;
   logic [NPAIR-1:0][DIST_W-1:0]      wd_q;
   logic [DIST_W-1:0]                 last_d_q;

   logic [NUM_COLS-1:0][NUM_COLS-1:0][DIST_W-1:0] dist_tab;
   logic dist_last;
   logic [NUM_COLS-1:0] rep;
   logic [NUM_COLS-1:0][CODE_W-1:0] code;
   logic [NUM_COLS-1:0][COL_ROWS-1:0] slots;
   logic [CNT_W-1:0] cnt;
   logic pick_found;
   logic [IDX_W-1:0] pick_a, pick_b;
   logic [DIST_W-1:0] pick_d;

   bcc_dist_engine #(.NUM_COLS(NUM_COLS), .COL_ROWS(COL_ROWS),
                     .IDX_W(IDX_W), .DIST_W(DIST_W)) u_dist (
      .clk(clk), .rst_n(rst_n), .run(state_q == ST_DIST), .tile(tile_q),
      .dist_tab(dist_tab), .last(dist_last));

   bcc_remap #(.NUM_COLS(NUM_COLS), .COL_ROWS(COL_ROWS), .IDX_W(IDX_W),
               .CODE_W(CODE_W), .DIST_W(DIST_W), .CNT_W(CNT_W)) u_remap (
      .tile(tile_q), .dist_tab(dist_tab), .rep(rep), .code(code),
      .slots(slots), .cnt(cnt));

   bcc_pair_picker #(.NUM_COLS(NUM_COLS), .COL_ROWS(COL_ROWS),
                     .IDX_W(IDX_W), .DIST_W(DIST_W)) u_pick (
      .dist_tab(dist_tab), .eligible(rep & ~used_q), .found(pick_found),
      .best_a(pick_a), .best_b(pick_b), .best_d(pick_d));

   assign busy_o = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tile_q      <= '0;
         round_q     <= '0;
         used_q      <= '0;
         wcnt_q      <= '0;
         wa_q        <= '0;
         wb_q        <= '0;
         wd_q        <= '0;
         last_d_q    <= '0;
         done_o      <= 1'b0;
         slot_cnt_o  <= '0;
         slot_cols_o <= '0;
         remap_o     <= '1;
         pair_cnt_o  <= '0;
         pair_a_o    <= '0;
         pair_b_o    <= '0;
         pair_dist_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  tile_q   <= tile_i;
                  used_q   <= '0;
                  wcnt_q   <= '0;
                  wa_q     <= '0;
                  wb_q     <= '0;
                  wd_q     <= '0;
                  last_d_q <= '0;
                  state_q  <= ST_DIST;
               end
            end
            ST_DIST: begin
               round_q <= '0;
               if (dist_last) state_q <= ST_PICK;
            end
            ST_PICK: begin
               if (pick_found) begin
                  wa_q[wcnt_q[PIDX_W-1:0]] <= pick_a;
                  wb_q[wcnt_q[PIDX_W-1:0]] <= pick_b;
                  wd_q[wcnt_q[PIDX_W-1:0]] <= pick_d;
                  used_q[pick_a]           <= 1'b1;
                  used_q[pick_b]           <= 1'b1;
                  wcnt_q                   <= wcnt_q + PCNT_W'(1);
                  last_d_q                 <= pick_d;
               end
               round_q <= round_q + PCNT_W'(1);
               if (round_q == PCNT_W'(NPAIR - 1)) state_q <= ST_DONE;
            end
            ST_DONE: begin
               slot_cnt_o  <= cnt;
               slot_cols_o <= slots;
               remap_o     <= code;
               pair_cnt_o  <= wcnt_q;
               pair_a_o    <= wa_q;
               pair_b_o    <= wb_q;
               pair_dist_o <= wd_q;
               done_o      <= 1'b1;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R3: completion is a single-cycle pulse
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R3: the distance sweep hands over to pairing right after its last pair
   assert_sweep_handover_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dist_last |=> (state_q == ST_PICK));
   // R2: a start request while busy leaves the accepted tile untouched
   assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(tile_q));
   // R8: greedy choice never picks a closer pair after a farther one
   assert_greedy_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PICK) && pick_found && (wcnt_q != '0)) |-> (pick_d >= last_d_q));
   // R10: results stay put unless the completion pulse is being raised
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_DONE) |=> ($stable(remap_o) && $stable(slot_cnt_o) && $stable(pair_cnt_o)));

   for (genvar k = 0; k < NUM_COLS; k++) begin : g_col_chk
      // R4: an empty column always carries the drop code
      assert_zero_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |-> ((|tile_q[k*COL_ROWS +: COL_ROWS]) || (remap_o[k*CODE_W +: CODE_W] == DROP_CODE)));
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair_chk
      // R9: listed pairs join two different stored slots, lower index first
      assert_pair_members_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (done_o && (PCNT_W'(p) < pair_cnt_o)) |->
            ((pair_a_o[p*IDX_W +: IDX_W] < pair_b_o[p*IDX_W +: IDX_W]) &&
             (remap_o[pair_a_o[p*IDX_W +: IDX_W]*CODE_W +: CODE_W] != DROP_CODE) &&
             (remap_o[pair_a_o[p*IDX_W +: IDX_W]*CODE_W +: CODE_W] !=
              remap_o[pair_b_o[p*IDX_W +: IDX_W]*CODE_W +: CODE_W])));
   end
endmodule

// File: tb/bitcol_compactor_tb.sv
module bitcol_compactor_tb;
   localparam int C    = 8;
   localparam int R    = 16;
   localparam int W    = C * R;
   localparam int IW   = 3;
   localparam int MW   = 4;
   localparam int DW   = 5;
   localparam int PN   = C / 2;
   localparam int NPR  = C * (C - 1) / 2;
   localparam int DONE_K = NPR + PN + 2;
   localparam int DROP = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [W-1:0] tile_i = '0;
   logic busy_o, done_o;
   logic [3:0] slot_cnt_o;
   logic [W-1:0] slot_cols_o;
   logic [C*MW-1:0] remap_o;
   logic [2:0] pair_cnt_o;
   logic [PN*IW-1:0] pair_a_o, pair_b_o;
   logic [PN*DW-1:0] pair_dist_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   bitcol_compactor #(.NUM_COLS(C), .COL_ROWS(R)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tile_i(tile_i),
      .busy_o(busy_o), .done_o(done_o), .slot_cnt_o(slot_cnt_o),
      .slot_cols_o(slot_cols_o), .remap_o(remap_o), .pair_cnt_o(pair_cnt_o),
      .pair_a_o(pair_a_o), .pair_b_o(pair_b_o), .pair_dist_o(pair_dist_o));

   // reference results
   int e_kind[C];   // 0 empty, 1 repeat, 2 stored
   int e_code[C];
   int e_slot[C];
   int e_cnt;
   int e_pc;
   int e_pa[PN], e_pb[PN], e_pd[PN];

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int colof(input logic [W-1:0] t, input int k);
      return int'(t[k*R +: R]);
   endfunction

   task automatic model(input logic [W-1:0] t);
      int used[C];
      e_cnt = 0;
      e_pc  = 0;
      for (int k = 0; k < C; k++) begin e_slot[k] = 0; used[k] = 0; end
      for (int k = 0; k < PN; k++) begin e_pa[k] = 0; e_pb[k] = 0; e_pd[k] = 0; end
      for (int j = 0; j < C; j++) begin
         int first;
         first = -1;
         if (colof(t, j) == 0) begin
            e_kind[j] = 0; e_code[j] = DROP;
         end else begin
            for (int i = 0; i < j; i++)
               if (first < 0 && colof(t, i) == colof(t, j)) first = i;
            if (first >= 0) begin
               e_kind[j] = 1; e_code[j] = e_code[first];
            end else begin
               e_kind[j] = 2; e_code[j] = e_cnt;
               e_slot[e_cnt] = colof(t, j);
               e_cnt++;
            end
         end
      end
      for (int rnd = 0; rnd < PN; rnd++) begin
         int ba, bb, bd;
         ba = -1; bb = -1; bd = 0;
         for (int a = 0; a < C; a++)
            for (int b = a + 1; b < C; b++)
               if (e_kind[a] == 2 && e_kind[b] == 2 && used[a] == 0 && used[b] == 0) begin
                  int d;
                  d = $countones(colof(t, a) ^ colof(t, b));
                  if (ba < 0 || d < bd) begin ba = a; bb = b; bd = d; end
               end
         if (ba >= 0) begin
            e_pa[e_pc] = ba; e_pb[e_pc] = bb; e_pd[e_pc] = bd;
            used[ba] = 1; used[bb] = 1;
            e_pc++;
         end
      end
   endtask

   task automatic check_results(input string when);
      chk({"R6 slot count ", when}, int'(slot_cnt_o), e_cnt);
      for (int s = 0; s < C; s++)
         chk({"R6 slot data ", when}, int'(slot_cols_o[s*R +: R]), e_slot[s]);
      for (int k = 0; k < C; k++) begin
         if (e_kind[k] == 0)      chk({"R4 empty column code ", when}, int'(remap_o[k*MW +: MW]), e_code[k]);
         else if (e_kind[k] == 1) chk({"R5 repeat column code ", when}, int'(remap_o[k*MW +: MW]), e_code[k]);
         else                     chk({"R6 stored column code ", when}, int'(remap_o[k*MW +: MW]), e_code[k]);
      end
      chk({"R9 pair count ", when}, int'(pair_cnt_o), e_pc);
      for (int p = 0; p < PN; p++) begin
         chk({"R8 pair first index ", when}, int'(pair_a_o[p*IW +: IW]), e_pa[p]);
         chk({"R8 pair second index ", when}, int'(pair_b_o[p*IW +: IW]), e_pb[p]);
         chk({"R7 pair distance ", when}, int'(pair_dist_o[p*DW +: DW]), e_pd[p]);
      end
   endtask

   // drive at a negative edge, sample only at negative edges
   task automatic run_tile(input logic [W-1:0] t, input bit poke, input logic [W-1:0] t2);
      model(t);
      tile_i  = t;
      start_i = 1'b1;
      @(posedge clk);
      for (int k = 1; k <= DONE_K + 1; k++) begin
         @(negedge clk);
         chk("R3 busy per cycle", int'(busy_o), (k < DONE_K) ? 1 : 0);
         chk("R3 done per cycle", int'(done_o), (k == DONE_K) ? 1 : 0);
         if (k == DONE_K)     check_results("at done");
         if (k == DONE_K + 1) check_results("R10 held");
         if (k == 1) start_i = 1'b0;
         if (poke && k == 5) begin start_i = 1'b1; tile_i = t2; end   // R2
         if (poke && k == 6) start_i = 1'b0;
      end
   endtask

   function automatic logic [W-1:0] mk(input int c0, c1, c2, c3, c4, c5, c6, c7);
      logic [W-1:0] t;
      t = {R'(c7), R'(c6), R'(c5), R'(c4), R'(c3), R'(c2), R'(c1), R'(c0)};
      return t;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R3 watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      int pal[4];
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy after reset", int'(busy_o), 0);
      chk("R1 done after reset", int'(done_o), 0);
      chk("R1 slot count after reset", int'(slot_cnt_o), 0);
      chk("R1 pair count after reset", int'(pair_cnt_o), 0);
      chk("R1 slots after reset", int'(slot_cols_o != '0), 0);
      chk("R1 remap after reset", int'(remap_o == '1), 1);
      chk("R1 pairs after reset", int'((pair_a_o | pair_b_o) != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle without start", int'(busy_o), 0);

      // R4: every column empty
      run_tile('0, 1'b0, '0);
      // R8: equal distances everywhere, ties go to lowest indices
      run_tile(mk(1, 2, 4, 8, 16, 32, 64, 128), 1'b0, '0);
      // R5: repeats and empties mixed
      run_tile(mk('h00F0, 0, 'h00F0, 'h1234, 'h1234, 0, 'hFFFF, 'h00F0), 1'b0, '0);
      // R5: all columns equal
      run_tile(mk('hA5A5, 'hA5A5, 'hA5A5, 'hA5A5, 'hA5A5, 'hA5A5, 'hA5A5, 'hA5A5), 1'b0, '0);
      // R8: distinct distances, greedy not index order
      run_tile(mk('h000F, 'hFF00, 'h001F, 'hFF01, 'h0F0F, 'hF0F0, 'h003F, 'h8000), 1'b0, '0);
      // R2: start while busy is ignored
      run_tile(mk('h0001, 'h0003, 0, 'h0007, 'h0001, 'hF000, 0, 'hF001), 1'b1,
               mk('hFFFF, 'hEEEE, 'hDDDD, 'hCCCC, 'hBBBB, 'hAAAA, 'h9999, 'h8888));
      // R9: odd number of stored columns
      run_tile(mk('h0101, 'h0202, 'h0404, 0, 0, 0, 0, 0), 1'b0, '0);

      lfsr = 32'h1D2C3B4A;
      for (int n = 0; n < 8; n++) begin
         logic [W-1:0] t;
         for (int q = 0; q < 4; q++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            pal[q] = (q == 0) ? 0 : int'(lfsr[15:0]);
         end
         for (int k = 0; k < C; k++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            if (n >= 4) t[k*R +: R] = lfsr[31:16];
            else        t[k*R +: R] = R'(pal[lfsr[1:0]]);
         end
         run_tile(t, 1'b0, '0);   // R6 R7 R8 mixed patterns
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule